// File: doc/BRIEF.md
# Fast A20 and Reset Control Port

This block is a one-byte system control register that answers at a single address on a synchronous, byte-wide I/O bus. A write stores the whole byte. Bit 1 of the stored byte drives the A20 address-gate line continuously. When a write sets bit 0 and the stored bit 0 was clear, the block issues a one-cycle reset request to the platform's reset logic. A read returns the stored byte.

There are two ways to reset the block. The power-on reset is asynchronous and active low, and it clears the whole byte, so A20 starts disabled. A synchronous soft device reset clears only bit 0. The A20 bit and every other stored bit keep their values, so a warm restart does not lose the gate setting. Every access the block decodes is acknowledged one cycle later. For a read, the data is returned in that same acknowledge cycle.

Top module: `a20ctl_port`

## Requirements
- R1: After power-on reset (porRst_n low) the stored byte is 0x00. a20Gate, resetReq, ioAck and ioRData are all 0.
- R2: A write to address 0x92 stores ioWData verbatim. A later read of 0x92 returns that byte on ioRData, in the cycle in which ioAck is high.
- R3: a20Gate equals bit 1 of the stored byte, starting from the clock edge that captures a write.
- R4: A write that sets bit 0 while the stored bit 0 is 0 raises resetReq for exactly one cycle, starting at the clock edge that captures the write.
- R5: A write that leaves bit 0 at 1, or that writes bit 0 as 0, raises no reset request.
- R6: While softRst is high at a clock edge, bit 0 is cleared and bits 7:1 are kept. A write in that same cycle is dropped.
- R7: An access to any address other than 0x92 leaves the stored byte unchanged. It gets no ioAck, and ioRData stays 0.
- R8: If ioWr and ioRd are both high for 0x92, the write is performed and ioRData shows the value stored before that write.
- R9: ioAck is high for one cycle after each decoded access. ioRData is 0 in any cycle that does not follow a decoded read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Asynchronous power-on reset, active low; clears the whole byte |
| softRst | input | 1 | Synchronous device reset; clears bit 0 only |
| ioAddr | input | ADDR_W (16) | I/O address |
| ioWr | input | 1 | Write strobe |
| ioRd | input | 1 | Read strobe |
| ioWData | input | DATA_W (8) | Write data |
| ioRData | output | DATA_W (8) | Registered read data |
| ioAck | output | 1 | Access acknowledge, one cycle after a decoded access |
| a20Gate | output | 1 | A20 address-gate enable |
| resetReq | output | 1 | One-cycle system reset request |

## Verification
The bench uses the default parameters: a 16-bit address, an 8-bit data bus and the port at 0x92. With a 16-bit address, the bench can use addresses that share the low byte with the port, such as 0x0192, and so show that the decode compares every address bit rather than only the low byte. The 8-bit data width lets the bench check that the bits around A20 and the reset bit are stored and read back without change across both kinds of reset.

// File: rtl/a20ctl_pkg.sv
package a20ctl_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ioStrobe_t;
endpackage

// File: rtl/a20ctl_ctrl.sv
module a20ctl_ctrl #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input  logic                    clk,
  input  logic                    porRst_n,
  input  logic                    softRst,
  input  logic [ADDR_W-1:0]       ioAddr,
  input  logic                    ioWr,
  input  logic                    ioRd,
  output a20ctl_pkg::ioStrobe_t   strb,
  output logic                    ioAck
);
  logic addrHit;

  assign addrHit = (ioAddr == PORT_ADDR);

  always_comb begin
    strb.wrEn = addrHit && ioWr && !softRst;
    strb.rdEn = addrHit && ioRd;
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) ioAck <= 1'b0;
    else           ioAck <= addrHit && (ioWr || ioRd);
  end
endmodule

// File: rtl/a20ctl_datapath.sv
module a20ctl_datapath #(
  parameter int DATA_W  = 8,
  parameter int A20_BIT = 1,
  parameter int RST_BIT = 0
) (
  input  logic                  clk,
  input  logic                  porRst_n,
  input  logic                  softRst,
  input  a20ctl_pkg::ioStrobe_t strb,
  input  logic [DATA_W-1:0]     ioWData,
  output logic [DATA_W-1:0]     ioRData,
  output logic                  a20Gate,
  output logic                  resetReq
);
  logic [DATA_W-1:0] ctlReg;
  logic [DATA_W-1:0] ctlNext;
  logic              riseBit;

  always_comb begin
    ctlNext = ctlReg;
    if (softRst)        ctlNext[RST_BIT] = 1'b0;
    else if (strb.wrEn) ctlNext = ioWData;
  end

  assign riseBit = strb.wrEn && ioWData[RST_BIT] && !ctlReg[RST_BIT];

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      ctlReg   <= '0;
      ioRData  <= '0;
      resetReq <= 1'b0;
    end else begin
      ctlReg   <= ctlNext;
      ioRData  <= strb.rdEn ? ctlReg : '0;
      resetReq <= riseBit;
    end
  end

  assign a20Gate = ctlReg[A20_BIT];
endmodule

// File: rtl/a20ctl_port.sv
module a20ctl_port #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              softRst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic [DATA_W-1:0] ioWData,
  output logic [DATA_W-1:0] ioRData,
  output logic              ioAck,
  output logic              a20Gate,
  output logic              resetReq
);
  localparam int A20_BIT = 1;
  localparam int RST_BIT = 0;

  a20ctl_pkg::ioStrobe_t strb;

  a20ctl_ctrl #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_ctrl (
    .clk(clk), .porRst_n(porRst_n), .softRst(softRst),
    .ioAddr(ioAddr), .ioWr(ioWr), .ioRd(ioRd),
    .strb(strb), .ioAck(ioAck)
  );

  a20ctl_datapath #(.DATA_W(DATA_W), .A20_BIT(A20_BIT), .RST_BIT(RST_BIT)) u_dp (
    .clk(clk), .porRst_n(porRst_n), .softRst(softRst),
    .strb(strb), .ioWData(ioWData),
    .ioRData(ioRData), .a20Gate(a20Gate), .resetReq(resetReq)
  );
endmodule

// File: rtl/a20ctl_checker.sv
module a20ctl_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0092
) (
  input logic              clk,
  input logic              porRst_n,
  input logic              softRst,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWr,
  input logic              ioRd,
  input logic [DATA_W-1:0] ioWData,
  input logic [DATA_W-1:0] ioRData,
  input logic              ioAck,
  input logic              a20Gate,
  input logic              resetReq
);
  // R3: a captured write sets the gate from its bit 1
  a_r3_a20_follows: assert property (@(posedge clk) disable iff (!porRst_n)
    (ioWr && ioAddr == PORT_ADDR && !softRst) |=> (a20Gate == $past(ioWData[1])));

  // R4: the request lasts one cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!porRst_n)
    resetReq |=> !resetReq);

  // R4/R5: a request needs a decoded write with bit 0 set
  a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!porRst_n)
    $rose(resetReq) |-> $past(ioWr && ioAddr == PORT_ADDR && ioWData[0] && !softRst));

  // R6: soft reset keeps the gate
  a_r6_soft_keeps_a20: assert property (@(posedge clk) disable iff (!porRst_n)
    softRst |=> (a20Gate == $past(a20Gate)));

  // R7: foreign addresses get no acknowledge
  a_r7_no_foreign_ack: assert property (@(posedge clk) disable iff (!porRst_n)
    ((ioWr || ioRd) && ioAddr != PORT_ADDR) |=> !ioAck);

  // R9: acknowledge only follows a decoded access
  a_r9_ack_cause: assert property (@(posedge clk) disable iff (!porRst_n)
    $rose(ioAck) |-> $past((ioWr || ioRd) && ioAddr == PORT_ADDR));

  // R9: read data is zero unless a read was decoded
  a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!porRst_n)
    !(ioRd && ioAddr == PORT_ADDR) |=> (ioRData == '0));
endmodule

bind a20ctl_port a20ctl_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk(clk), .porRst_n(porRst_n), .softRst(softRst), .ioAddr(ioAddr),
  .ioWr(ioWr), .ioRd(ioRd), .ioWData(ioWData), .ioRData(ioRData),
  .ioAck(ioAck), .a20Gate(a20Gate), .resetReq(resetReq)
);

// File: tb/test_a20ctl_port.sv
module test_a20ctl_port;
  logic        clk = 1'b0;
  logic        porRst_n = 1'b0;
  logic        softRst = 1'b0;
  logic [15:0] ioAddr = '0;
  logic        ioWr = 1'b0;
  logic        ioRd = 1'b0;
  logic [7:0]  ioWData = '0;
  logic [7:0]  ioRData;
  logic        ioAck;
  logic        a20Gate;
  logic        resetReq;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  logic [7:0] shadow = 8'h00;

  always #10 clk = ~clk;

  a20ctl_port i_a20ctl_port (
    .clk(clk), .porRst_n(porRst_n), .softRst(softRst), .ioAddr(ioAddr),
    .ioWr(ioWr), .ioRd(ioRd), .ioWData(ioWData), .ioRData(ioRData),
    .ioAck(ioAck), .a20Gate(a20Gate), .resetReq(resetReq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every acknowledge pops one expected read-data item (R2, R8, R9)
  always @(negedge clk) begin
    if (porRst_n && ioAck === 1'b1) begin
      if (expQ.size() == 0) check("R7/R9 unexpected ack", 8'h01, 8'h00);
      else check("R2/R8/R9 ack data", ioRData, expQ.pop_front());
    end
  end

  task automatic doAccess(input logic [15:0] a, input logic wr, input logic rd,
                          input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWr = wr; ioRd = rd; ioWData = d;
    if (a == 16'h0092) begin
      expQ.push_back(rd ? shadow : 8'h00);
      if (wr && !softRst) shadow = d;
    end
    @(negedge clk);
    ioWr = 1'b0; ioRd = 1'b0;
  endtask

  task automatic idleCheckPulseGone();
    @(negedge clk);
    check("R4 pulse one cycle", {7'd0, resetReq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 a20", {7'd0, a20Gate}, 8'h00);
    check("R1 resetReq", {7'd0, resetReq}, 8'h00);
    check("R1 ack", {7'd0, ioAck}, 8'h00);
    check("R1 rdata", ioRData, 8'h00);
    porRst_n = 1'b1;
    doAccess(16'h0092, 0, 1, 8'h00);                  // R1 read back 0x00
    doAccess(16'h0092, 1, 0, 8'h02);                  // R3, R5
    check("R3 a20 set", {7'd0, a20Gate}, 8'h01);
    check("R5 no pulse on bit0=0", {7'd0, resetReq}, 8'h00);
    doAccess(16'h0092, 0, 1, 8'h00);                  // R2
    doAccess(16'h0092, 1, 0, 8'hA5);                  // R4 rising bit 0
    check("R4 pulse", {7'd0, resetReq}, 8'h01);
    check("R3 a20 clear", {7'd0, a20Gate}, 8'h00);
    idleCheckPulseGone();
    doAccess(16'h0092, 1, 0, 8'hA7);                  // R5 1 over 1
    check("R5 no pulse 1 over 1", {7'd0, resetReq}, 8'h00);
    check("R3 a20 on", {7'd0, a20Gate}, 8'h01);
    // R6 soft reset
    @(negedge clk); softRst = 1'b1;
    @(negedge clk); softRst = 1'b0; shadow = shadow & 8'hFE;
    check("R6 a20 kept", {7'd0, a20Gate}, 8'h01);
    doAccess(16'h0092, 0, 1, 8'h00);                  // expect 0xA6
    doAccess(16'h0092, 1, 0, 8'h93);                  // R4 again
    check("R4 second pulse", {7'd0, resetReq}, 8'h01);
    idleCheckPulseGone();
    // R7 foreign accesses
    doAccess(16'h0192, 1, 0, 8'h00);
    doAccess(16'h0093, 0, 1, 8'h00);
    check("R7 foreign rdata", ioRData, 8'h00);
    check("R7 foreign no ack", {7'd0, ioAck}, 8'h00);
    doAccess(16'h0092, 0, 1, 8'h00);                  // still 0x93
    // R8 both strobes
    doAccess(16'h0092, 1, 1, 8'h5C);
    doAccess(16'h0092, 0, 1, 8'h00);                  // 0x5C
    // R6 soft reset with simultaneous write: write dropped
    @(negedge clk);
    softRst = 1'b1;
    ioAddr = 16'h0092; ioWr = 1'b1; ioWData = 8'hFF;
    expQ.push_back(8'h00);
    @(negedge clk);
    softRst = 1'b0; ioWr = 1'b0;
    check("R6 write dropped", {7'd0, a20Gate}, 8'h00);
    check("R6 no pulse", {7'd0, resetReq}, 8'h00);
    doAccess(16'h0092, 0, 1, 8'h00);                  // 0x5C
    // R1 power-on reset mid-run
    @(negedge clk); porRst_n = 1'b0;
    @(negedge clk); porRst_n = 1'b1; shadow = 8'h00;
    doAccess(16'h0092, 0, 1, 8'h00);
    @(negedge clk);
    check("R2/R9 queue drained", 8'(expQ.size()), 8'h00);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule